// File: doc/BRIEF.md
# Reservation-Aware Hardware Spinlock Unit

This block holds a bank of single-bit hardware locks shared by a set of processing elements (PEs). Every PE also owns a reservation slot that records which lock it intends to take next, a small priority code for that lock, a "wants it" flag and a "holds the reservation" flag. Each PE issues four kinds of request on its own request channel: reserve, acquire, release and drop-reservation. Each request gets a one-cycle response that says whether it succeeded.

An acquire wins only when the lock is free and no other PE holds a reservation on it that the requester lacks. Several PEs may hold the reservation of one lock together, and any of them may then take it. Reservations are granted from outside the block through a decision port. The reservation slots are presented as outputs so that an external decision engine can read the lock IDs and priority codes. How that engine decides, and when it runs, is outside this block.

Request channels are valid/ready. `req_ready` is held high, so a request is accepted on every cycle its `req_valid` is high and the requester never waits. The response side has no back-pressure: `rsp_valid` pulses for exactly one cycle, and the requester must take it then.

Top module: `resv_spinlock_unit`

## Requirements
- R1: After reset, all locks are free, every reservation slot has both flags clear, and no response is valid.
- R2: `req_ready` is always high. Each accepted request produces `rsp_valid` on the next cycle for the same PE. `rsp_ok` is 1 for reserve, release and drop requests. Op codes: 0 reserve, 1 acquire, 2 release, 3 drop-reservation.
- R3: A reserve request stores `req_data[7:0]` as the slot's lock ID and `req_data[11:8]` as its priority code, and ignores bits 31:12. It sets the want flag, clears the held flag and leaves every lock's state unchanged.
- R4: An acquire of a lock (ID in `req_data[7:0]`) that is already locked fails.
- R5: An acquire of a free lock that nobody holds a reservation on succeeds, and the lock becomes locked.
- R6: An acquire of a free lock fails when another PE's slot names that lock with its held flag set and the requester's slot does not.
- R7: An acquire of a free lock succeeds when the requester's own slot names that lock with its held flag set, even when other PEs also hold that reservation.
- R8: A release from any PE frees the named lock, whoever took it.
- R9: A drop-reservation request clears both the want and held flags of that PE's slot. A drop takes precedence over a decision-port grant in the same cycle.
- R10: A decision-port pulse (`dec_valid`) sets the held flag of each PE whose `dec_mask` bit is set, whose want flag is set and whose lock ID equals `dec_lock`. No other slot changes.
- R11: When several eligible acquires name the same lock in one cycle, the lowest-numbered PE wins and the others get a failure.
- R12: An acquire is judged against the lock and reservation state from before the cycle's own updates. A release or reservation change in the same cycle does not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NP | Request valid, one bit per PE |
| req_ready | output | NP | Request ready, always high |
| req_op | input | 2*NP | Op code per PE (2 bits each) |
| req_data | input | 32*NP | Request word per PE (32 bits each) |
| rsp_valid | output | NP | Response valid per PE |
| rsp_ok | output | NP | Response success per PE |
| dec_valid | input | 1 | Reservation decision strobe |
| dec_lock | input | 8 | Lock the decision applies to |
| dec_mask | input | NP | PEs to mark as holding the reservation |
| rsv_lock | output | 8*NP | Lock ID stored in each slot |
| rsv_info | output | 4*NP | Priority code stored in each slot |
| rsv_want | output | NP | Want flag of each slot |
| rsv_held | output | NP | Held flag of each slot |

## Verification
The bench targets these corner cases:
- An acquire on a free lock that is reserved only for others, which a plain lock unit would wrongly grant.
- Two holders of one reservation, where a design that allows only one holder would refuse the second.
- Two PEs racing for the same lock, where a missing arbiter grants both or picks the wrong winner.
- A release in the same cycle as another PE's acquire, where a design that forwards the release grants too early.
- A reserve word with junk in its upper bits, which exposes a misplaced field.
- A decision pulse for a slot that has already dropped its request, which a design that skips the want check would wrongly mark as held.

// File: rtl/rsl_pkg.sv
package rsl_pkg;
  typedef enum logic [1:0] {
    OP_RESERVE = 2'd0,
    OP_ACQUIRE = 2'd1,
    OP_RELEASE = 2'd2,
    OP_DROP    = 2'd3
  } rsl_op_e;

  localparam int WORD_W    = 32;
  localparam int INFO_LSB  = 8;
endpackage

// File: rtl/rsl_resv_bank.sv
module rsl_resv_bank #(
  parameter int NP     = 12,
  parameter int LOCK_W = 8,
  parameter int INFO_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NP-1:0]        wr_en,
  input  logic [NP-1:0]        drop_en,
  input  logic [NP*LOCK_W-1:0] wr_lock,
  input  logic [NP*INFO_W-1:0] wr_info,
  input  logic                 dec_valid,
  input  logic [LOCK_W-1:0]    dec_lock,
  input  logic [NP-1:0]        dec_mask,
  output logic [NP*LOCK_W-1:0] slot_lock,
  output logic [NP*INFO_W-1:0] slot_info,
  output logic [NP-1:0]        slot_want,
  output logic [NP-1:0]        slot_held
);
  for (genvar p = 0; p < NP; p++) begin : g_slot
    logic [LOCK_W-1:0] id_q;
    logic [INFO_W-1:0] info_q;
    logic              want_q;
    logic              held_q;
    logic              dec_hit;

    assign dec_hit = dec_valid && dec_mask[p] && want_q && (id_q == dec_lock);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        id_q   <= '0;
        info_q <= '0;
        want_q <= 1'b0;
        held_q <= 1'b0;
      end else if (drop_en[p]) begin
        want_q <= 1'b0;
        held_q <= 1'b0;
      end else if (wr_en[p]) begin
        id_q   <= wr_lock[p*LOCK_W +: LOCK_W];
        info_q <= wr_info[p*INFO_W +: INFO_W];
        want_q <= 1'b1;
        held_q <= 1'b0;
      end else if (dec_hit) begin
        held_q <= 1'b1;
      end
    end

    assign slot_lock[p*LOCK_W +: LOCK_W] = id_q;
    assign slot_info[p*INFO_W +: INFO_W] = info_q;
    assign slot_want[p]                  = want_q;
    assign slot_held[p]                  = held_q;
  end
endmodule

// File: rtl/rsl_grant_eval.sv
module rsl_grant_eval #(
  parameter int NP     = 12,
  parameter int LOCK_W = 8,
  localparam int NLOCK = 1 << LOCK_W
) (
  input  logic [NP-1:0]        acq_en,
  input  logic [NP*LOCK_W-1:0] acq_lock,
  input  logic [NLOCK-1:0]     lock_state,
  input  logic [NP*LOCK_W-1:0] slot_lock,
  input  logic [NP-1:0]        slot_held,
  output logic [NP-1:0]        grant
);
  logic [LOCK_W-1:0] want_id [NP];
  logic [LOCK_W-1:0] own_id  [NP];
  logic [NP-1:0]     eligible;

  for (genvar p = 0; p < NP; p++) begin : g_unpack
    assign want_id[p] = acq_lock[p*LOCK_W +: LOCK_W];
    assign own_id[p]  = slot_lock[p*LOCK_W +: LOCK_W];
  end

  // eligibility: lock free, and not fenced off by a reservation held elsewhere
  always_comb begin
    for (int p = 0; p < NP; p++) begin
      logic fenced;
      logic mine;
      fenced = 1'b0;
      for (int q = 0; q < NP; q++) begin
        if (q != p && slot_held[q] && own_id[q] == want_id[p]) fenced = 1'b1;
      end
      mine = slot_held[p] && (own_id[p] == want_id[p]);
      eligible[p] = acq_en[p] && !lock_state[want_id[p]] && !(fenced && !mine);
    end
  end

  // fixed priority per lock: lowest PE index wins
  always_comb begin
    for (int p = 0; p < NP; p++) begin
      logic beaten;
      beaten = 1'b0;
      for (int j = 0; j < p; j++) begin
        if (eligible[j] && want_id[j] == want_id[p]) beaten = 1'b1;
      end
      grant[p] = eligible[p] && !beaten;
    end
  end
endmodule

// File: rtl/rsl_lock_array.sv
module rsl_lock_array #(
  parameter int NP     = 12,
  parameter int LOCK_W = 8,
  localparam int NLOCK = 1 << LOCK_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NP-1:0]        set_en,
  input  logic [NP*LOCK_W-1:0] set_lock,
  input  logic [NP-1:0]        clr_en,
  input  logic [NP*LOCK_W-1:0] clr_lock,
  output logic [NLOCK-1:0]     state
);
  logic [NLOCK-1:0] state_nxt;

  always_comb begin
    state_nxt = state;
    for (int p = 0; p < NP; p++) begin
      if (clr_en[p]) state_nxt[clr_lock[p*LOCK_W +: LOCK_W]] = 1'b0;
    end
    for (int p = 0; p < NP; p++) begin
      if (set_en[p]) state_nxt[set_lock[p*LOCK_W +: LOCK_W]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= '0;
    else        state <= state_nxt;
  end
endmodule

// File: rtl/resv_spinlock_unit.sv
module resv_spinlock_unit #(
  parameter int NP     = 12,
  parameter int LOCK_W = 8,
  parameter int INFO_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NP-1:0]        req_valid,
  output logic [NP-1:0]        req_ready,
  input  logic [2*NP-1:0]      req_op,
  input  logic [32*NP-1:0]     req_data,
  output logic [NP-1:0]        rsp_valid,
  output logic [NP-1:0]        rsp_ok,
  input  logic                 dec_valid,
  input  logic [LOCK_W-1:0]    dec_lock,
  input  logic [NP-1:0]        dec_mask,
  output logic [NP*LOCK_W-1:0] rsv_lock,
  output logic [NP*INFO_W-1:0] rsv_info,
  output logic [NP-1:0]        rsv_want,
  output logic [NP-1:0]        rsv_held
);
  import rsl_pkg::*;

  localparam int NLOCK  = 1 << LOCK_W;
  localparam int SPARE  = WORD_W - INFO_LSB - INFO_W;

  logic [NP-1:0]        is_resv, is_acq, is_rel, is_drop;
  logic [NP*LOCK_W-1:0] req_lock;
  logic [NP*INFO_W-1:0] req_info;
  logic [NP*SPARE-1:0]  unused_spare;
  logic [NP-1:0]        grant;
  logic [NLOCK-1:0]     lock_state;

  for (genvar p = 0; p < NP; p++) begin : g_dec
    rsl_op_e op;
    assign op       = rsl_op_e'(req_op[2*p +: 2]);
    assign is_resv[p] = req_valid[p] && (op == OP_RESERVE);
    assign is_acq[p]  = req_valid[p] && (op == OP_ACQUIRE);
    assign is_rel[p]  = req_valid[p] && (op == OP_RELEASE);
    assign is_drop[p] = req_valid[p] && (op == OP_DROP);
    assign req_lock[p*LOCK_W +: LOCK_W] = req_data[WORD_W*p +: LOCK_W];
    assign req_info[p*INFO_W +: INFO_W] = req_data[WORD_W*p + INFO_LSB +: INFO_W];
    assign unused_spare[p*SPARE +: SPARE] = req_data[WORD_W*p + INFO_LSB + INFO_W +: SPARE];
  end

  assign req_ready = '1;

  rsl_resv_bank #(.NP(NP), .LOCK_W(LOCK_W), .INFO_W(INFO_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (is_resv),
    .drop_en   (is_drop),
    .wr_lock   (req_lock),
    .wr_info   (req_info),
    .dec_valid (dec_valid),
    .dec_lock  (dec_lock),
    .dec_mask  (dec_mask),
    .slot_lock (rsv_lock),
    .slot_info (rsv_info),
    .slot_want (rsv_want),
    .slot_held (rsv_held)
  );

  rsl_grant_eval #(.NP(NP), .LOCK_W(LOCK_W)) u_eval (
    .acq_en     (is_acq),
    .acq_lock   (req_lock),
    .lock_state (lock_state),
    .slot_lock  (rsv_lock),
    .slot_held  (rsv_held),
    .grant      (grant)
  );

  rsl_lock_array #(.NP(NP), .LOCK_W(LOCK_W)) u_locks (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (grant),
    .set_lock (req_lock),
    .clr_en   (is_rel),
    .clr_lock (req_lock),
    .state    (lock_state)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= '0;
      rsp_ok    <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_ok    <= (req_valid & ~is_acq) | grant;
    end
  end
endmodule

// File: rtl/rsl_checker.sv
module rsl_checker #(
  parameter int NP     = 12,
  parameter int LOCK_W = 8,
  parameter int INFO_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NP-1:0]        req_valid,
  input logic [NP-1:0]        req_ready,
  input logic [2*NP-1:0]      req_op,
  input logic [32*NP-1:0]     req_data,
  input logic [NP-1:0]        rsp_valid,
  input logic [NP-1:0]        rsp_ok,
  input logic [NP*LOCK_W-1:0] rsv_lock,
  input logic [NP-1:0]        rsv_want,
  input logic [NP-1:0]        rsv_held
);
  a_r2_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == {NP{1'b1}});

  for (genvar p = 0; p < NP; p++) begin : g_pe
    a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[p] |=> rsp_valid[p]);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid[p] |=> !rsp_valid[p]);
    a_r3_reserve_stores: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[p] && req_op[2*p +: 2] == 2'd0) |=>
        (rsv_want[p] && !rsv_held[p] &&
         rsv_lock[p*LOCK_W +: LOCK_W] == $past(req_data[32*p +: LOCK_W])));
    a_r9_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[p] && req_op[2*p +: 2] == 2'd3) |=> (!rsv_want[p] && !rsv_held[p]));
    a_r10_held_implies_want: assert property (@(posedge clk) disable iff (!rst_n)
      rsv_held[p] |-> rsv_want[p]);
    for (genvar q = p + 1; q < NP; q++) begin : g_pair
      a_r11_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid[p] && req_valid[q] &&
         req_op[2*p +: 2] == 2'd1 && req_op[2*q +: 2] == 2'd1 &&
         req_data[32*p +: LOCK_W] == req_data[32*q +: LOCK_W])
        |=> !(rsp_ok[p] && rsp_ok[q]));
    end
  end

  logic unused_chk;
  assign unused_chk = ^req_data;
endmodule

bind resv_spinlock_unit rsl_checker #(.NP(NP), .LOCK_W(LOCK_W), .INFO_W(INFO_W)) u_chk (.*);

// File: tb/resv_spinlock_unit_test.sv
`timescale 1ns/1ps
module resv_spinlock_unit_test;
  localparam int NP = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NP-1:0]    req_valid = '0;
  logic [NP-1:0]    req_ready;
  logic [2*NP-1:0]  req_op = '0;
  logic [32*NP-1:0] req_data = '0;
  logic [NP-1:0]    rsp_valid, rsp_ok;
  logic             dec_valid = 1'b0;
  logic [7:0]       dec_lock = '0;
  logic [NP-1:0]    dec_mask = '0;
  logic [8*NP-1:0]  rsv_lock;
  logic [4*NP-1:0]  rsv_info;
  logic [NP-1:0]    rsv_want, rsv_held;

  resv_spinlock_unit #(.NP(NP)) uut (.*);

  int checks = 0;
  int fails = 0;

  // model state
  bit         m_lock [256];
  logic [7:0] m_id   [NP];
  logic [3:0] m_info [NP];
  bit         m_want [NP];
  bit         m_held [NP];

  // drive set
  bit          d_v    [NP];
  logic [1:0]  d_op   [NP];
  logic [31:0] d_data [NP];
  bit          d_dv;
  logic [7:0]  d_dl;
  logic [NP-1:0] d_dm;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    for (int p = 0; p < NP; p++) begin d_v[p] = 0; d_op[p] = 0; d_data[p] = 0; end
    d_dv = 0; d_dl = 0; d_dm = '0;
  endtask

  task automatic put(input int p, input logic [1:0] op, input logic [31:0] data);
    d_v[p] = 1; d_op[p] = op; d_data[p] = data;
  endtask

  // apply one cycle of stimulus at a negedge, predict, check after the edge
  task automatic step();
    bit    elig [NP];
    bit    e_ok [NP];
    string tag  [NP];
    for (int p = 0; p < NP; p++) begin
      req_valid[p]        = d_v[p];
      req_op[2*p +: 2]    = d_op[p];
      req_data[32*p +: 32] = d_data[p];
    end
    dec_valid = d_dv; dec_lock = d_dl; dec_mask = d_dm;

    for (int p = 0; p < NP; p++) begin
      logic [7:0] lid;
      bit other, own;
      lid = d_data[p][7:0];
      other = 0;
      for (int q = 0; q < NP; q++)
        if (q != p && m_held[q] && m_id[q] == lid) other = 1;
      own = m_held[p] && m_id[p] == lid;
      elig[p] = d_v[p] && d_op[p] == 2'd1 && !m_lock[lid] && !(other && !own);
      if (!(d_v[p] && d_op[p] == 2'd1)) tag[p] = "R2";
      else if (m_lock[lid]) tag[p] = "R4";
      else if (other && !own) tag[p] = "R6";
      else if (own) tag[p] = "R7";
      else tag[p] = "R5";
    end
    for (int p = 0; p < NP; p++) begin
      bit beaten;
      beaten = 0;
      for (int j = 0; j < p; j++)
        if (elig[j] && d_data[j][7:0] == d_data[p][7:0]) beaten = 1;
      if (elig[p] && beaten) tag[p] = "R11";
      e_ok[p] = (d_v[p] && d_op[p] != 2'd1) || (elig[p] && !beaten);
    end
    // model update: releases, then grants
    for (int p = 0; p < NP; p++)
      if (d_v[p] && d_op[p] == 2'd2) m_lock[d_data[p][7:0]] = 0;
    for (int p = 0; p < NP; p++)
      if (d_v[p] && d_op[p] == 2'd1 && e_ok[p]) m_lock[d_data[p][7:0]] = 1;
    for (int p = 0; p < NP; p++) begin
      if (d_v[p] && d_op[p] == 2'd3) begin
        m_want[p] = 0; m_held[p] = 0;
      end else if (d_v[p] && d_op[p] == 2'd0) begin
        m_id[p] = d_data[p][7:0]; m_info[p] = d_data[p][11:8];
        m_want[p] = 1; m_held[p] = 0;
      end else if (d_dv && d_dm[p] && m_want[p] && m_id[p] == d_dl) begin
        m_held[p] = 1;
      end
    end

    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      string stag;
      logic [15:0] act, exp;
      check(rsp_valid[p] == d_v[p], "R2 rsp_valid", 64'(rsp_valid[p]), 64'(d_v[p]));
      if (d_v[p])
        check(rsp_ok[p] == e_ok[p], tag[p], 64'(rsp_ok[p]), 64'(e_ok[p]));
      if (d_v[p] && d_op[p] == 2'd0) stag = "R3 slot";
      else if (d_v[p] && d_op[p] == 2'd3) stag = "R9 slot";
      else stag = "R10 slot";
      act = {rsv_lock[8*p +: 8], rsv_info[4*p +: 4], 2'b00, rsv_want[p], rsv_held[p]};
      exp = {m_id[p], m_info[p], 2'b00, m_want[p], m_held[p]};
      check(act == exp, stag, 64'(act), 64'(exp));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) m_lock[i] = 0;
    for (int p = 0; p < NP; p++) begin m_id[p] = 0; m_info[p] = 0; m_want[p] = 0; m_held[p] = 0; end
    idle();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == '0, "R1 rsp_valid", 64'(rsp_valid), 64'd0);
    check(rsv_want == '0 && rsv_held == '0, "R1 flags", 64'({rsv_want, rsv_held}), 64'd0);

    // R1/R5: every PE takes its own lock after reset
    idle();
    for (int p = 0; p < NP; p++) put(p, 2'd1, 32'(100 + p));
    step();
    idle();
    for (int p = 0; p < NP; p++) put(p, 2'd2, 32'(100 + p));
    step();

    // R5 then R4
    idle(); put(0, 2'd1, 32'd10); step();
    idle(); put(1, 2'd1, 32'd10); step();
    // R12: release by PE6 and acquire by PE8 in the same cycle -> acquire fails
    idle(); put(6, 2'd2, 32'd10); put(8, 2'd1, 32'd10); step();
    // R8: lock now free, PE1 takes it
    idle(); put(1, 2'd1, 32'd10); step();
    idle(); put(1, 2'd2, 32'd10); step();

    // R3: junk in the upper bits
    idle(); put(2, 2'd0, 32'hDEAD_B514); put(3, 2'd0, 32'hFFFF_F714); put(4, 2'd0, 32'h1234_5014); step();
    // R10: reserve lock 0x14 for PE2 only; PE4 is outside the mask
    idle(); d_dv = 1; d_dl = 8'h14; d_dm = 12'h004; step();
    // R6: PE4 and PE3 blocked, R7: PE2 wins
    idle(); put(4, 2'd1, 32'h14); put(3, 2'd1, 32'h14); step();
    idle(); put(2, 2'd1, 32'h14); step();
    // second holder
    idle(); d_dv = 1; d_dl = 8'h14; d_dm = 12'h008; step();
    idle(); put(2, 2'd2, 32'h14); step();
    idle(); put(3, 2'd1, 32'h14); put(4, 2'd1, 32'h14); step();
    idle(); put(3, 2'd2, 32'h14); step();
    // R9: drop, then a decision for a dropped slot has no effect
    idle(); put(2, 2'd3, 32'h0); put(3, 2'd3, 32'h0); step();
    idle(); d_dv = 1; d_dl = 8'h14; d_dm = '1; step();
    idle(); put(5, 2'd1, 32'h14); step();
    idle(); put(5, 2'd2, 32'h14); step();
    // R9 precedence over a same-cycle decision
    idle(); put(7, 2'd0, 32'h22); step();
    idle(); put(7, 2'd3, 32'h0); d_dv = 1; d_dl = 8'h22; d_dm = '1; step();
    // R11: PE9 and PE7 race, PE7 wins
    idle(); put(9, 2'd1, 32'd30); put(7, 2'd1, 32'd30); step();
    idle(); put(7, 2'd2, 32'd30); step();

    // random phase
    for (int n = 0; n < 3000; n++) begin
      idle();
      for (int p = 0; p < NP; p++) begin
        if ($urandom_range(9) < 4) begin
          logic [7:0] lid;
          lid = ($urandom_range(7) == 0) ? 8'hFF : 8'($urandom_range(3));
          put(p, 2'($urandom_range(3)),
              {20'($urandom), 4'($urandom_range(15)), lid});
        end
      end
      if ($urandom_range(3) == 0) begin
        d_dv = 1; d_dl = 8'($urandom_range(3)); d_dm = NP'($urandom);
      end
      step();
    end

    idle(); step();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule